// File: doc/BRIEF.md
# Command Buffer Exchange Sequencer

This engine carries out one command/response exchange through a shared byte buffer RAM. A host-side register block programs four values: the command address, the command size, the response address and the response size. It then pulses `start`. The engine captures those values and turns each address into a buffer offset by subtracting the buffer's base address within the register window. It then checks that both windows lie inside the buffer. If either window does not fit, the exchange is rejected and nothing else happens.

For an accepted exchange the engine reads the command bytes out of the RAM and hands them to a backend on a valid/ready byte stream (`cmd_*`). The backend may stall at any byte by holding `cmd_ready` low. The engine keeps `cmd_valid` and `cmd_data` steady until the handshake completes.

Once the last command byte has been taken, the engine writes zero to every byte of the buffer, so no stale command data can be read back. Only after that does it raise `rsp_ready` and accept the backend's response stream (`rsp_*`), whose final byte carries `rsp_last`. Response bytes are stored from the response offset onward, up to the response size. Bytes beyond that size are accepted and dropped. `done` pulses at the end so the register block can clear its start bit, and `error` pulses along with `done` when an exchange is rejected.

Top module: `cmd_buffer_sequencer`

## Requirements
- R1: After reset, `cmd_valid`, `rsp_ready`, `done`, `error` and `ram_en` are all low.
- R2: Each offset is its address minus `BUF_BASE`. The exchange is rejected in any of these cases: either address is below `BUF_BASE`, either offset exceeds `BUF_BYTES`, or either offset plus its size exceeds `BUF_BYTES`. On a start sampled at clock edge k, a rejected exchange drives `done` and `error` high together during the cycle after edge k+1, for exactly one cycle. No command byte is offered and the RAM contents stay unchanged.
- R3: Two boundary cases are accepted: a window whose end equals `BUF_BYTES` exactly, and a window with offset equal to `BUF_BYTES` and size 0.
- R4: An accepted exchange offers exactly command-size bytes, taken from the RAM in ascending order starting at the command offset. While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` and `cmd_data` hold.
- R5: The four parameter inputs are sampled only in the cycle `start` is accepted; changes afterwards do not affect the running exchange.
- R6: Before the first response byte is accepted, every buffer byte is written with 0. `rsp_ready` stays low until that clearing completes, and it is never high while `cmd_valid` is high. Every RAM write outside the response phase writes 0.
- R7: Response byte k (counting from 0) is written to offset response-offset + k only when k is less than the response size. Later bytes are accepted and discarded, and all other buffer bytes end at 0.
- R8: The response byte carrying `rsp_last` ends the exchange. `done` then pulses for exactly one cycle with `error` low.
- R9: A `start` pulse while an exchange is in progress is ignored: no second exchange follows.
- R10: A command size of 0 offers no command bytes and goes straight to clearing the buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse to begin an exchange (ignored while busy) |
| cmd_addr | input | ADDR_W | Command window address in the register window |
| cmd_size | input | SIZE_W | Command length in bytes |
| rsp_addr | input | ADDR_W | Response window address in the register window |
| rsp_size | input | SIZE_W | Maximum response bytes to store |
| ram_en | output | 1 | Buffer RAM access enable |
| ram_we | output | 1 | Buffer RAM write enable (read when low) |
| ram_addr | output | $clog2(BUF_BYTES) | Buffer RAM byte address |
| ram_wdata | output | 8 | Buffer RAM write data |
| ram_rdata | input | 8 | Buffer RAM read data, one cycle after a read |
| cmd_valid | output | 1 | Command byte available |
| cmd_data | output | 8 | Command byte |
| cmd_ready | input | 1 | Backend accepts the command byte |
| rsp_valid | input | 1 | Response byte available |
| rsp_data | input | 8 | Response byte |
| rsp_last | input | 1 | Marks the final response byte |
| rsp_ready | output | 1 | Engine accepts a response byte |
| done | output | 1 | One-cycle end-of-exchange pulse |
| error | output | 1 | One-cycle rejection pulse, coincident with done |

## Verification
The bench builds the engine with `BUF_BYTES` = 96, `BUF_BASE` = 32, and 16-bit address and size fields. With these values the full clear pass takes under a hundred cycles, so every exchange can be followed byte by byte, and a bench array can model the whole buffer and compare it after each run. The smaller geometry also makes every window boundary easy to reach. It covers an end exactly at the buffer end, an offset equal to the buffer length, an address below the base, and overrun by one byte, as well as a command and response that both span the full buffer.

// File: rtl/csq_pkg.sv
package csq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_CHECK,
    SQ_SEND,
    SQ_SCRUB,
    SQ_RECV,
    SQ_DONE,
    SQ_REJECT
  } sq_state_e;

endpackage

// File: rtl/csq_window_check.sv
// Converts a window address into a buffer offset and decides whether the
// window [offset, offset+size) lies within the buffer.
module csq_window_check #(
  parameter int ADDR_W    = 32,
  parameter int SIZE_W    = 32,
  parameter int BUF_BYTES = 3968,
  parameter int BUF_BASE  = 128
) (
  input  logic [ADDR_W-1:0]                  win_addr,
  input  logic [SIZE_W-1:0]                  win_size,
  output logic                               win_ok,
  output logic [$clog2(BUF_BYTES+1)-1:0]     win_off
);
  localparam int OFF_W = $clog2(BUF_BYTES + 1);
  // Two guard bits keep offset+size from wrapping.
  localparam int EW = ((ADDR_W > SIZE_W) ? ADDR_W : SIZE_W) + 2;

  logic [EW-1:0] addr_x;
  logic [EW-1:0] size_x;
  logic [EW-1:0] off_x;
  logic [EW-1:0] end_x;
  logic          below_base;

  always_comb begin
    addr_x     = EW'(win_addr);
    size_x     = EW'(win_size);
    below_base = addr_x < EW'(BUF_BASE);
    off_x      = addr_x - EW'(BUF_BASE);
    end_x      = off_x + size_x;
    win_ok     = !below_base && (off_x <= EW'(BUF_BYTES)) && (end_x <= EW'(BUF_BYTES));
    win_off    = off_x[OFF_W-1:0];
  end

endmodule

// File: rtl/csq_cmd_reader.sv
// Fetches command bytes from the buffer RAM (one-cycle read latency) and
// presents them on a valid/ready byte stream.
module csq_cmd_reader #(
  parameter int BUF_BYTES = 3968
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               load,
  input  logic [$clog2(BUF_BYTES+1)-1:0]     load_off,
  input  logic [$clog2(BUF_BYTES+1)-1:0]     load_cnt,
  output logic                               rd_en,
  output logic [$clog2(BUF_BYTES)-1:0]       rd_addr,
  input  logic [7:0]                         rd_data,
  output logic                               m_valid,
  output logic [7:0]                         m_data,
  input  logic                               m_ready,
  output logic                               drained
);
  localparam int OFF_W  = $clog2(BUF_BYTES + 1);
  localparam int RAM_AW = $clog2(BUF_BYTES);

  logic [OFF_W-1:0] fetch_left_q;
  logic [OFF_W-1:0] send_left_q;
  logic [OFF_W-1:0] addr_q;
  logic             pend_q;
  logic             vld_q;
  logic [7:0]       data_q;
  logic             fire;
  logic             issue;

  assign fire  = vld_q && m_ready;
  // A read is issued only when its byte will have a free output slot.
  assign issue = !load && !pend_q && (fetch_left_q != '0) && (!vld_q || fire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_left_q <= '0;
      send_left_q  <= '0;
      addr_q       <= '0;
      pend_q       <= 1'b0;
      vld_q        <= 1'b0;
      data_q       <= '0;
    end else if (load) begin
      fetch_left_q <= load_cnt;
      send_left_q  <= load_cnt;
      addr_q       <= load_off;
      pend_q       <= 1'b0;
      vld_q        <= 1'b0;
    end else begin
      pend_q <= issue;
      if (issue) begin
        fetch_left_q <= fetch_left_q - 1'b1;
        addr_q       <= addr_q + 1'b1;
      end
      if (pend_q) begin
        data_q <= rd_data;
        vld_q  <= 1'b1;
      end else if (fire) begin
        vld_q <= 1'b0;
      end
      if (fire) begin
        send_left_q <= send_left_q - 1'b1;
      end
    end
  end

  assign rd_en   = issue;
  assign rd_addr = addr_q[RAM_AW-1:0];
  assign m_valid = vld_q;
  assign m_data  = data_q;
  assign drained = (send_left_q == '0) && !vld_q && !pend_q;

endmodule

// File: rtl/csq_rsp_writer.sv
// Accepts response bytes and places the first 'limit' of them at the
// response offset; extra bytes are consumed without a write.
module csq_rsp_writer #(
  parameter int BUF_BYTES = 3968
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               load,
  input  logic [$clog2(BUF_BYTES+1)-1:0]     load_off,
  input  logic [$clog2(BUF_BYTES+1)-1:0]     load_cnt,
  input  logic                               active,
  input  logic                               s_valid,
  input  logic [7:0]                         s_data,
  input  logic                               s_last,
  output logic                               s_ready,
  output logic                               wr_en,
  output logic [$clog2(BUF_BYTES)-1:0]       wr_addr,
  output logic [7:0]                         wr_data,
  output logic                               end_seen
);
  localparam int OFF_W  = $clog2(BUF_BYTES + 1);
  localparam int RAM_AW = $clog2(BUF_BYTES);

  logic [OFF_W-1:0] off_q;
  logic [OFF_W-1:0] lim_q;
  logic [OFF_W-1:0] cnt_q;
  logic [OFF_W-1:0] dest;
  logic             fire;
  logic             keep;

  assign fire = active && s_valid;
  assign keep = fire && (cnt_q < lim_q);
  assign dest = off_q + cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      lim_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      off_q <= load_off;
      lim_q <= load_cnt;
      cnt_q <= '0;
    end else if (keep) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign s_ready  = active;
  assign wr_en    = keep;
  assign wr_addr  = dest[RAM_AW-1:0];
  assign wr_data  = s_data;
  assign end_seen = fire && s_last;

endmodule

// File: rtl/cmd_buffer_sequencer.sv
module cmd_buffer_sequencer #(
  parameter int BUF_BYTES = 3968,
  parameter int BUF_BASE  = 128,
  parameter int ADDR_W    = 32,
  parameter int SIZE_W    = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  input  logic [ADDR_W-1:0]               cmd_addr,
  input  logic [SIZE_W-1:0]               cmd_size,
  input  logic [ADDR_W-1:0]               rsp_addr,
  input  logic [SIZE_W-1:0]               rsp_size,
  output logic                            ram_en,
  output logic                            ram_we,
  output logic [$clog2(BUF_BYTES)-1:0]    ram_addr,
  output logic [7:0]                      ram_wdata,
  input  logic [7:0]                      ram_rdata,
  output logic                            cmd_valid,
  output logic [7:0]                      cmd_data,
  input  logic                            cmd_ready,
  input  logic                            rsp_valid,
  input  logic [7:0]                      rsp_data,
  input  logic                            rsp_last,
  output logic                            rsp_ready,
  output logic                            done,
  output logic                            error
);
  import csq_pkg::*;

  localparam int OFF_W   = $clog2(BUF_BYTES + 1);
  localparam int RAM_AW  = $clog2(BUF_BYTES);
  localparam int N_WIN   = 2;   // index 0: command window, 1: response window
  localparam logic [RAM_AW-1:0] LAST_IDX = RAM_AW'(BUF_BYTES - 1);

  sq_state_e st_q, st_d;

  logic [ADDR_W-1:0] win_addr_q [N_WIN];
  logic [SIZE_W-1:0] win_size_q [N_WIN];
  logic [N_WIN-1:0]  win_ok;
  logic [OFF_W-1:0]  win_off    [N_WIN];
  logic [OFF_W-1:0]  win_cnt    [N_WIN];

  logic              accept;
  logic [RAM_AW-1:0] clr_q;
  logic              clr_last;

  logic              rd_en;
  logic [RAM_AW-1:0] rd_addr;
  logic              drained;
  logic              wr_en;
  logic [RAM_AW-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic              end_seen;

  // Parameter capture: only when a start is taken from idle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_WIN; i++) begin
        win_addr_q[i] <= '0;
        win_size_q[i] <= '0;
      end
    end else if (st_q == SQ_IDLE && start) begin
      win_addr_q[0] <= cmd_addr;
      win_size_q[0] <= cmd_size;
      win_addr_q[1] <= rsp_addr;
      win_size_q[1] <= rsp_size;
    end
  end

  generate
    for (genvar w = 0; w < N_WIN; w++) begin : g_win
      csq_window_check #(
        .ADDR_W   (ADDR_W),
        .SIZE_W   (SIZE_W),
        .BUF_BYTES(BUF_BYTES),
        .BUF_BASE (BUF_BASE)
      ) u_chk (
        .win_addr(win_addr_q[w]),
        .win_size(win_size_q[w]),
        .win_ok  (win_ok[w]),
        .win_off (win_off[w])
      );
      assign win_cnt[w] = OFF_W'(win_size_q[w]);
    end
  endgenerate

  assign accept   = (st_q == SQ_CHECK) && (&win_ok);
  assign clr_last = (clr_q == LAST_IDX);

  // Sequencer state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_IDLE:   if (start) st_d = SQ_CHECK;
      SQ_CHECK:  st_d = (&win_ok) ? SQ_SEND : SQ_REJECT;
      SQ_SEND:   if (drained) st_d = SQ_SCRUB;
      SQ_SCRUB:  if (clr_last) st_d = SQ_RECV;
      SQ_RECV:   if (end_seen) st_d = SQ_DONE;
      SQ_DONE:   st_d = SQ_IDLE;
      SQ_REJECT: st_d = SQ_IDLE;
      default:   st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  // Scrub index walks the whole buffer once per exchange.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           clr_q <= '0;
    else if (st_q == SQ_SCRUB && !clr_last) clr_q <= clr_q + 1'b1;
    else                                  clr_q <= '0;
  end

  csq_cmd_reader #(.BUF_BYTES(BUF_BYTES)) u_reader (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .load_off(win_off[0]),
    .load_cnt(win_cnt[0]),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (ram_rdata),
    .m_valid (cmd_valid),
    .m_data  (cmd_data),
    .m_ready (cmd_ready),
    .drained (drained)
  );

  csq_rsp_writer #(.BUF_BYTES(BUF_BYTES)) u_writer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .load_off(win_off[1]),
    .load_cnt(win_cnt[1]),
    .active  (st_q == SQ_RECV),
    .s_valid (rsp_valid),
    .s_data  (rsp_data),
    .s_last  (rsp_last),
    .s_ready (rsp_ready),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .end_seen(end_seen)
  );

  // RAM port ownership follows the phase.
  always_comb begin
    ram_en    = 1'b0;
    ram_we    = 1'b0;
    ram_addr  = '0;
    ram_wdata = '0;
    unique case (st_q)
      SQ_SEND: begin
        ram_en   = rd_en;
        ram_addr = rd_addr;
      end
      SQ_SCRUB: begin
        ram_en   = 1'b1;
        ram_we   = 1'b1;
        ram_addr = clr_q;
      end
      SQ_RECV: begin
        ram_en    = wr_en;
        ram_we    = wr_en;
        ram_addr  = wr_addr;
        ram_wdata = wr_data;
      end
      default: ;
    endcase
  end

  assign done  = (st_q == SQ_DONE) || (st_q == SQ_REJECT);
  assign error = (st_q == SQ_REJECT);

endmodule

// File: rtl/csq_sva.sv
module csq_sva #(
  parameter int BUF_BYTES = 3968
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          ram_en,
  input logic                          ram_we,
  input logic [$clog2(BUF_BYTES)-1:0]  ram_addr,
  input logic [7:0]                    ram_wdata,
  input logic                          cmd_valid,
  input logic [7:0]                    cmd_data,
  input logic                          cmd_ready,
  input logic                          rsp_valid,
  input logic                          rsp_ready,
  input logic                          done,
  input logic                          error
);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r2_error_has_done: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);

  a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));

  a_r6_phase_apart: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !rsp_ready);

  a_r6_scrub_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && ram_we && !rsp_ready) |-> (ram_wdata == 8'h00));

  a_r7_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> (32'(ram_addr) < BUF_BYTES));

  a_r7_write_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && rsp_ready) |-> rsp_valid);

endmodule

bind cmd_buffer_sequencer csq_sva #(.BUF_BYTES(BUF_BYTES)) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .ram_en   (ram_en),
  .ram_we   (ram_we),
  .ram_addr (ram_addr),
  .ram_wdata(ram_wdata),
  .cmd_valid(cmd_valid),
  .cmd_data (cmd_data),
  .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .done     (done),
  .error    (error)
);

// File: tb/cmd_buffer_sequencer_tb.sv
`timescale 1ns/1ps
module cmd_buffer_sequencer_tb;
  localparam int BUF  = 96;
  localparam int BASE = 32;
  localparam int AW   = 16;
  localparam int SW   = 16;
  localparam int RAW  = $clog2(BUF);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] cmd_addr = '0, rsp_addr = '0;
  logic [SW-1:0] cmd_size = '0, rsp_size = '0;
  logic ram_en, ram_we;
  logic [RAW-1:0] ram_addr;
  logic [7:0] ram_wdata;
  logic [7:0] ram_rdata = '0;
  logic cmd_valid;
  logic [7:0] cmd_data;
  logic cmd_ready = 1'b0;
  logic rsp_valid = 1'b0;
  logic [7:0] rsp_data = '0;
  logic rsp_last = 1'b0;
  logic rsp_ready, done, error;

  always #5 clk = ~clk;

  cmd_buffer_sequencer #(.BUF_BYTES(BUF), .BUF_BASE(BASE), .ADDR_W(AW), .SIZE_W(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cmd_addr(cmd_addr), .cmd_size(cmd_size), .rsp_addr(rsp_addr), .rsp_size(rsp_size),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last), .rsp_ready(rsp_ready),
    .done(done), .error(error));

  // Buffer RAM model, one-cycle read latency
  logic [7:0] mem [BUF];
  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      else        ram_rdata <= mem[ram_addr];
    end
  end

  int checks = 0;
  int errs = 0;
  logic [7:0] exp_q [$];
  logic prev_rdy = 1'b0;
  int ncyc = 0;

  task automatic check(bit ok, string req, string what, longint got, longint expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, expv);
    end
  endtask

  function automatic logic [7:0] rsp_byte(int seed, int k);
    return 8'(8'h41 + k * 3 + seed);
  endfunction

  task automatic fill(int seed);
    for (int i = 0; i < BUF; i++) mem[i] = 8'h80 | 8'(i * 5 + seed);
  endtask

  // Monitor: backend stall pattern, command scoreboard, scrub check
  always @(negedge clk) begin
    ncyc++;
    cmd_ready = (ncyc % 3) != 0;
    if (rst_n && cmd_valid && cmd_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4", "unexpected command byte", cmd_data, 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(cmd_data == e, "R4", "command byte", cmd_data, e);
      end
    end
    if (rst_n && rsp_ready && !prev_rdy) begin
      int nz = 0;
      for (int i = 0; i < BUF; i++) if (mem[i] != 8'h00) nz++;
      check(nz == 0, "R6", "nonzero bytes when response opens", nz, 0);
    end
    prev_rdy = rsp_ready;
  end

  // Watchdog
  always @(posedge clk) begin
    if (ncyc > 150000) begin
      errs++;
      checks++;
      $display("FAIL watchdog: got %0d expected %0d", ncyc, 150000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic pulse_start(int ca, int cs, int ra, int rs);
    @(negedge clk);
    start = 1'b1;
    cmd_addr = AW'(ca); cmd_size = SW'(cs);
    rsp_addr = AW'(ra); rsp_size = SW'(rs);
    @(negedge clk);
    start = 1'b0;
    // R5: scrambled inputs after the start would be rejected if re-sampled
    cmd_addr = '0; cmd_size = '1; rsp_addr = '1; rsp_size = '1;
  endtask

  task automatic drive_rsp(int n, int seed);
    int k = 0;
    int guard = 0;
    while (k < n && guard < 20000) begin
      rsp_valid = 1'b1;
      rsp_data  = rsp_byte(seed, k);
      rsp_last  = (k == n - 1);
      if (rsp_ready) k++;
      @(negedge clk);
      guard++;
      if (k % 4 == 3 && k < n) begin
        rsp_valid = 1'b0; rsp_last = 1'b0;
        @(negedge clk);
      end
    end
    rsp_valid = 1'b0;
    rsp_last  = 1'b0;
  endtask

  task automatic run_exch(string tag, int ca, int cs, int ra, int rs, int n, int seed, bit poke);
    int coff = ca - BASE;
    int roff = ra - BASE;
    int guard = 0;
    int bad = 0, first_i = -1;
    logic [7:0] expm [BUF];
    fill(seed);
    for (int k = 0; k < cs; k++) exp_q.push_back(mem[coff + k]);
    pulse_start(ca, cs, ra, rs);
    if (poke) begin
      @(negedge clk);
      start = 1'b1;  // R9: busy, must be ignored
      @(negedge clk);
      start = 1'b0;
    end
    drive_rsp(n, seed);
    while (!done && guard < 5000) begin @(negedge clk); guard++; end
    check(done == 1'b1, "R8", {tag, " done seen"}, done, 1);
    check(error == 1'b0, "R8", {tag, " error low at done"}, error, 0);
    check(exp_q.size() == 0, "R4", {tag, " command bytes left unsent"}, exp_q.size(), 0);
    exp_q.delete();
    @(negedge clk);
    check(done == 1'b0, "R8", {tag, " done single cycle"}, done, 0);
    for (int i = 0; i < BUF; i++) expm[i] = 8'h00;
    for (int k = 0; k < n && k < rs; k++) expm[roff + k] = rsp_byte(seed, k);
    for (int i = 0; i < BUF; i++) if (mem[i] !== expm[i]) begin
      bad++;
      if (first_i < 0) first_i = i;
    end
    check(bad == 0, "R7", {tag, " buffer image mismatches"}, bad, 0);
    if (bad != 0) $display("  first mismatch at %0d: got %0h expected %0h", first_i, mem[first_i], expm[first_i]);
    begin
      int act = 0;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        if (cmd_valid || done || rsp_ready) act++;
      end
      check(act == 0, "R9", {tag, " no activity after done"}, act, 0);
    end
  endtask

  task automatic run_rej(string tag, int ca, int cs, int ra, int rs, int seed);
    logic [7:0] snap [BUF];
    int diff = 0, act = 0;
    fill(seed);
    for (int i = 0; i < BUF; i++) snap[i] = mem[i];
    pulse_start(ca, cs, ra, rs);
    // now in the cycle after the sampling edge (window check)
    @(negedge clk);
    check(done == 1'b1 && error == 1'b1, "R2", {tag, " done+error pulse"}, {done, error}, 2'b11);
    @(negedge clk);
    check(done == 1'b0 && error == 1'b0, "R2", {tag, " pulse lasts one cycle"}, {done, error}, 2'b00);
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (cmd_valid || rsp_ready || ram_en) act++;
    end
    check(act == 0, "R2", {tag, " no stream or RAM activity"}, act, 0);
    for (int i = 0; i < BUF; i++) if (mem[i] != snap[i]) diff++;
    check(diff == 0, "R2", {tag, " RAM untouched"}, diff, 0);
  endtask

  initial begin
    for (int i = 0; i < BUF; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!cmd_valid && !rsp_ready && !done && !error && !ram_en, "R1", "outputs quiet in reset",
          {cmd_valid, rsp_ready, done, error, ram_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!cmd_valid && !rsp_ready && !done && !error && !ram_en, "R1", "outputs quiet after reset",
          {cmd_valid, rsp_ready, done, error, ram_en}, 0);

    run_exch("R4 R5 R9 basic",          BASE + 4,  10, BASE + 20, 8,  8,  1, 1'b1);
    run_exch("R7 short response",       BASE + 8,  5,  BASE + 8,  12, 5,  2, 1'b0);
    run_exch("R7 clipped response",     BASE,      3,  BASE + 68, 4,  9,  3, 1'b0);
    run_exch("R10 zero command",        BASE + 28, 0,  BASE + 1,  3,  3,  4, 1'b0);
    run_exch("R3 windows at end",       BASE + 86, 10, BASE + 96, 0,  2,  5, 1'b0);
    run_exch("R6 full buffer",          BASE,      96, BASE,      96, 96, 6, 1'b0);

    run_rej("R2 command overrun",  BASE + 90, 7, BASE, 4, 7);
    run_rej("R2 response offset",  BASE, 4, BASE + 97, 0, 8);
    run_rej("R2 below base",       10, 1, BASE, 4, 9);
    run_rej("R2 response size",    BASE, 1, BASE, 97, 10);

    run_exch("R8 after rejects",    BASE + 50, 6, BASE + 40, 6, 6, 11, 1'b0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule